// File: doc/BRIEF.md
# Configurable SPI Master/Slave Controller

A byte-oriented serial peripheral that exchanges one data word at a time over a four-wire synchronous serial link. Software configures it through an 8-bit control register, polls or takes an interrupt from a completion flag, and moves data through a data register. As master it derives the serial clock from the system clock, shifts the transmit word out on MOSI and captures MISO. As slave it follows an external serial clock while its select input is low.

Bit order, clock idle level and clock phase can be changed at run time. As master, a low select input is treated as a bus conflict: the block demotes itself to slave, aborts any transfer and raises the completion flag, so software sees the event.

Top module: `spi_ctrl_top`

## Requirements
- R1: The control register (address 0) holds, from bit 7 down to bit 0: interrupt enable, module enable, LSB-first, master select, clock idle-high, late sample, rate bit 1, rate bit 0. It resets to 0x00 and reads back what was written. The status register (address 1) has the completion flag in bit 7 and reads 0x00 after reset.
- R2: With module enable at 0, writing the data register (address 2) starts nothing: SCK stays at its idle level and the completion flag stays 0.
- R3: With LSB-first at 1, bit 0 of the word is shifted first. With LSB-first at 0, bit 7 is shifted first. This applies to both transmit and receive.
- R4: As master, a write to the data register while idle sends exactly 8 bits on MOSI and captures 8 bits from MISO. It then sets the completion flag, and a data register read returns the received byte.
- R5: As master, a low select input clears the master select bit and sets the completion flag. The block returns to master mode only when software writes the master bit again.
- R6: As master, SCK rests at 0 when idle-high is 0 and at 1 when it is 1, before and after every transfer.
- R7: With late sample at 0, input bits are sampled on the leading SCK edge and output bits change on the trailing edge. With late sample at 1, outputs change on the leading edge and inputs are sampled on the trailing edge.
- R8: As master, rate codes 0, 1, 2 and 3 give SCK periods of 4, 16, 64 and 128 system clocks, so SCK edges are 2, 8, 32 and 64 system clocks apart.
- R9: The interrupt output is 1 exactly when the completion flag, the interrupt enable bit and the global interrupt enable input are all 1.
- R10: The completion flag clears only after a status read that sees it set is followed by a data register access. A data read alone leaves the flag set.
- R11: As slave, a high select input disables the MISO output (enable 0) and makes incoming SCK edges have no effect. With select low, the block shifts on the external SCK, and the rate bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register |
| global_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data input (slave) |
| mosi_o | output | 1 | Serial data output (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data input (master) |
| miso_o | output | 1 | Serial data output (slave) |
| miso_oe | output | 1 | MISO output enable |
| ss_n | input | 1 | Active-low select input |

## Verification
The hardest case to reach is a slave transfer in which every external SCK edge has to land on the intended side of the synchronizer. Otherwise sample and setup edges swap, and the byte comes out shifted by one bit. The bench acts as a peer master. It spaces its SCK and MOSI changes eight system clocks apart, and reads MISO just before it makes each sample edge. It also toggles SCK with select high before a transfer, to show that the bit counter holds. In master mode the bench acts as a peer slave. It drives MISO only on the setup edges it sees, so a phase error shows up as wrong received data.

// File: rtl/spi_pkg.sv
package spi_pkg;

   typedef struct packed {
      logic       irq_en;
      logic       enable;
      logic       lsb_first;
      logic       is_master;
      logic       idle_hi;
      logic       late_sample;
      logic [1:0] rate;
   } spi_ctrl_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int           W      = 3,
   parameter int           STAGES = 2,
   parameter logic [W-1:0] RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4) else $fatal(1, "spi_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
   parameter int DIV0 = 4,
   parameter int DIV1 = 16,
   parameter int DIV2 = 64,
   parameter int DIV3 = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       idle_hi,
   input  logic [1:0] rate,
   output logic       tick,
   output logic       sck_o
);

   localparam int MAXH = spi_pkg::max4(DIV0 / 2, DIV1 / 2, DIV2 / 2, DIV3 / 2);
   localparam int CW   = (MAXH > 2) ? $clog2(MAXH) : 1;

   initial begin
      assert (DIV0 >= 4 && DIV0 % 2 == 0) else $fatal(1, "spi_sck_gen: DIV0 must be even and >= 4");
      assert (DIV1 >= 4 && DIV1 % 2 == 0) else $fatal(1, "spi_sck_gen: DIV1 must be even and >= 4");
      assert (DIV2 >= 4 && DIV2 % 2 == 0) else $fatal(1, "spi_sck_gen: DIV2 must be even and >= 4");
      assert (DIV3 >= 4 && DIV3 % 2 == 0) else $fatal(1, "spi_sck_gen: DIV3 must be even and >= 4");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] half_m1;
   logic          sck_q;

   always_comb begin
      unique case (rate)
         2'd0:    half_m1 = CW'(DIV0 / 2 - 1);
         2'd1:    half_m1 = CW'(DIV1 / 2 - 1);
         2'd2:    half_m1 = CW'(DIV2 / 2 - 1);
         default: half_m1 = CW'(DIV3 / 2 - 1);
      endcase
   end

   assign tick  = run && (cnt == half_m1);
   assign sck_o = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sck_q <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         sck_q <= idle_hi;
      end else if (cnt == half_m1) begin
         cnt   <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R8: two SCK edges are never one system clock apart
   assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R6: outside a transfer the SCK level only follows the idle setting
   assert_idle_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> sck_o == $past(idle_hi));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          is_master,
   input  logic          late_sample,
   input  logic          lsb_first,
   input  logic          load_req,
   input  logic [DW-1:0] load_data,
   input  logic          abort,
   input  logic          m_tick,
   input  logic          s_edge,
   input  logic          s_sel,
   input  logic          master_in,
   input  logic          slave_in,
   output logic          busy,
   output logic          out_bit,
   output logic          done,
   output logic [DW-1:0] rx_data
);

   localparam int EW   = $clog2(2 * DW);
   localparam int IW   = $clog2(DW);
   localparam int LAST = 2 * DW - 1;

   initial begin
      assert (DW >= 2) else $fatal(1, "spi_shift_core: DW must be >= 2");
   end

   logic [EW-1:0] ecnt;
   logic [DW-1:0] txr;
   logic [DW-1:0] rxr;
   logic [EW-1:0] eadj;
   logic [IW-1:0] idx;
   logic [IW-1:0] sel;
   logic          load_ok;
   logic          start;
   logic          adv;
   logic          samp_now;
   logic          in_bit;

   assign load_ok  = enable && load_req && (is_master ? !busy : (ecnt == '0));
   assign start    = load_ok && is_master;
   assign adv      = is_master ? (busy && m_tick) : (s_sel && s_edge);
   assign samp_now = adv && (ecnt[0] == late_sample);
   assign in_bit   = is_master ? master_in : slave_in;

   always_comb begin
      if (late_sample) eadj = (ecnt == '0) ? '0 : (ecnt - 1'b1);
      else             eadj = ecnt;
      idx = IW'(eadj >> 1);
      sel = lsb_first ? idx : (IW'(DW - 1) - idx);
   end

   assign out_bit = txr[sel];
   assign rx_data = rxr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txr <= '0;
         rxr <= '0;
      end else begin
         if (load_ok) txr <= load_data;
         if (samp_now && enable && !abort) begin
            if (lsb_first) rxr <= {in_bit, rxr[DW-1:1]};
            else           rxr <= {rxr[DW-2:0], in_bit};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!enable || abort) begin
            ecnt <= '0;
            busy <= 1'b0;
         end else if (start) begin
            ecnt <= '0;
            busy <= 1'b1;
         end else if (!is_master && !s_sel) begin
            ecnt <= '0;
            busy <= 1'b0;
         end else if (is_master && !busy) begin
            ecnt <= '0;
         end else if (adv) begin
            if (ecnt == EW'(LAST)) begin
               ecnt <= '0;
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               ecnt <= ecnt + 1'b1;
            end
         end
      end
   end

   // R2: a disabled block holds no transfer state
   assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (ecnt == '0 && !busy));

   // R11: an unselected slave keeps its bit counter at zero
   assert_unselected_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_master && !s_sel) |=> (ecnt == '0));

   // R4: completion is a single-cycle event
   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/spi_regs.sv
module spi_regs #(
   parameter int DW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               rd,
   input  logic [1:0]         addr,
   input  logic [DW-1:0]      wdata,
   input  logic               fault,
   input  logic               done,
   input  logic [DW-1:0]      rx_data,
   input  logic               gie,
   output spi_pkg::spi_ctrl_t ctrl,
   output logic               data_wr,
   output logic               irq,
   output logic [DW-1:0]      rdata
);
   import spi_pkg::*;

   initial begin
      assert (DW >= 8) else $fatal(1, "spi_regs: DW must be >= 8");
   end

   logic          flag;
   logic          armed;
   logic          data_acc;
   logic [DW-1:0] dbuf;

   assign data_wr  = wr && (addr == ADDR_DATA);
   assign data_acc = (wr || rd) && (addr == ADDR_DATA);
   assign irq      = flag && ctrl.irq_en && gie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr && addr == ADDR_CTRL) ctrl <= spi_ctrl_t'(wdata[7:0]);
         if (fault) ctrl.is_master <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
         dbuf  <= '0;
      end else begin
         if (done) dbuf <= rx_data;
         if (done || fault)          flag <= 1'b1;
         else if (armed && data_acc) flag <= 1'b0;
         if (armed && data_acc)                         armed <= 1'b0;
         else if (rd && addr == ADDR_STAT && flag)      armed <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADDR_CTRL: rdata[7:0] = ctrl;
         ADDR_STAT: rdata[7]   = flag;
         ADDR_DATA: rdata      = dbuf;
         default:   rdata      = '0;
      endcase
   end

   // R5: a mode fault demotes to slave and raises the flag
   assert_fault_demotes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!ctrl.is_master && flag));

   // R4: a finished word always raises the flag
   assert_flag_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> flag);

   // R10: the flag only drops after the status read armed the clear
   assert_clear_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(armed));

endmodule

// File: rtl/spi_ctrl_top.sv
module spi_ctrl_top #(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DIV0        = 4,
   parameter int DIV1        = 16,
   parameter int DIV2        = 64,
   parameter int DIV3        = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          global_irq_en,
   output logic          irq,
   input  logic          sck_i,
   output logic          sck_o,
   output logic          sck_oe,
   input  logic          mosi_i,
   output logic          mosi_o,
   output logic          mosi_oe,
   input  logic          miso_i,
   output logic          miso_o,
   output logic          miso_oe,
   input  logic          ss_n
);
   import spi_pkg::*;

   spi_ctrl_t     ctrl;
   logic          data_wr;
   logic          fault;
   logic          busy;
   logic          tick;
   logic          out_bit;
   logic          xfer_done;
   logic [DW-1:0] rx_data;
   logic [2:0]    sync_q;
   logic          sck_s, mosi_s, ss_s;
   logic          sck_d;
   logic          s_edge;
   logic          s_sel;

   spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ss_n, sck_i, mosi_i}),
      .q     (sync_q)
   );
   assign {ss_s, sck_s, mosi_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign s_edge = sck_s ^ sck_d;
   assign s_sel  = ctrl.enable && !ctrl.is_master && !ss_s;
   assign fault  = ctrl.enable && ctrl.is_master && !ss_s;

   spi_regs #(.DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .rd      (reg_rd),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .fault   (fault),
      .done    (xfer_done),
      .rx_data (rx_data),
      .gie     (global_irq_en),
      .ctrl    (ctrl),
      .data_wr (data_wr),
      .irq     (irq),
      .rdata   (reg_rdata)
   );

   spi_sck_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_sck (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .idle_hi (ctrl.idle_hi),
      .rate    (ctrl.rate),
      .tick    (tick),
      .sck_o   (sck_o)
   );

   spi_shift_core #(.DW(DW)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (ctrl.enable),
      .is_master   (ctrl.is_master),
      .late_sample (ctrl.late_sample),
      .lsb_first   (ctrl.lsb_first),
      .load_req    (data_wr),
      .load_data   (reg_wdata),
      .abort       (fault),
      .m_tick      (tick),
      .s_edge      (s_edge),
      .s_sel       (s_sel),
      .master_in   (miso_i),
      .slave_in    (mosi_s),
      .busy        (busy),
      .out_bit     (out_bit),
      .done        (xfer_done),
      .rx_data     (rx_data)
   );

   assign sck_oe  = ctrl.enable && ctrl.is_master;
   assign mosi_oe = ctrl.enable && ctrl.is_master;
   assign mosi_o  = out_bit;
   assign miso_o  = out_bit;
   assign miso_oe = s_sel;

   // R6: a finished master transfer leaves SCK at its idle level
   assert_sck_rests_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && ctrl.is_master && $stable(ctrl.idle_hi)) |-> (sck_o == ctrl.idle_hi));

   // R9: no interrupt while the global enable is low
   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !global_irq_en |-> !irq);

endmodule

// File: tb/tb_spi_ctrl_top.sv
module tb_spi_ctrl_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       global_irq_en = 1'b1;
   logic       irq;
   logic       sck_i = 1'b0, sck_o, sck_oe;
   logic       mosi_i = 1'b0, mosi_o, mosi_oe;
   logic       miso_i = 1'b0, miso_o, miso_oe;
   logic       ss_n = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   spi_ctrl_top dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .global_irq_en(global_irq_en), .irq(irq),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
      .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n(ss_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor side of the scoreboard: pop the next expected item and compare
   task automatic sb_check(input string tag, input logic [7:0] act);
      logic [7:0] e;
      if (exp_q.size() == 0) begin
         chk({tag, " (queue empty)"}, 32'd0, 32'd1);
      end else begin
         e = exp_q.pop_front();
         chk(tag, act, e);
      end
   endtask

   function automatic int bp(input logic lf, input int i);
      return lf ? i : 7 - i;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // read data, show that a lone data read keeps the flag, then clear it
   task automatic finish_clear(input string tag);
      logic [7:0] v;
      rd(2'd2, v);  sb_check({tag, " R4 received byte"}, v);
      rd(2'd1, v);  chk({tag, " R10 flag survives data read"}, v, 8'h80);
      rd(2'd2, v);
      rd(2'd1, v);  chk({tag, " R10 flag cleared"}, v, 8'h00);
   endtask

   // driver for master mode: bench plays the peer slave
   task automatic m_xfer(input logic [7:0] cfg, input logic [7:0] txb,
                         input logic [7:0] peer, input int half, input string tag);
      logic cf, cp, lf, prev, leading, samp;
      logic [7:0] got;
      int si, mi, gap;
      cf = cfg[3]; cp = cfg[2]; lf = cfg[5];
      got = 8'h00; si = 0; mi = 0;
      wr(2'd0, cfg);
      @(negedge clk);
      chk({tag, " R6 idle level before"}, sck_o, cf);
      exp_q.push_back(txb);
      exp_q.push_back(peer);
      if (!cp) begin miso_i = peer[bp(lf, 0)]; mi = 1; end
      wr(2'd2, txb);
      prev = cf;
      for (int k = 0; k < 16; k++) begin
         gap = 0;
         do begin @(negedge clk); gap++; end while (sck_o === prev && gap < 5000);
         prev = sck_o;
         if (k > 0) chk({tag, " R8 edge spacing"}, gap, half);
         leading = (k % 2 == 0);
         samp    = (leading == !cp);
         if (samp) begin
            got[bp(lf, si)] = mosi_o; si++;
         end else if (mi < 8) begin
            miso_i = peer[bp(lf, mi)]; mi++;
         end
      end
      repeat (4) @(negedge clk);
      chk({tag, " R6 idle level after"}, sck_o, cf);
      sb_check({tag, " R3 R7 MOSI byte"}, got);
   endtask

   // driver for slave mode: bench plays the peer master
   task automatic s_xfer(input logic [7:0] cfg, input logic [7:0] txb,
                         input logic [7:0] mb, input string tag);
      logic cf, cp, lf;
      logic [7:0] got;
      cf = cfg[3]; cp = cfg[2]; lf = cfg[5];
      got = 8'h00;
      wr(2'd0, cfg);
      sck_i = cf;
      wr(2'd2, txb);
      exp_q.push_back(txb);
      exp_q.push_back(mb);
      repeat (4) @(negedge clk);
      ss_n = 1'b0;
      repeat (8) @(negedge clk);
      chk({tag, " R11 MISO enabled when selected"}, miso_oe, 1'b1);
      for (int i = 0; i < 8; i++) begin
         if (!cp) begin
            mosi_i = mb[bp(lf, i)];
            repeat (8) @(negedge clk);
            got[bp(lf, i)] = miso_o;
            sck_i = ~cf;
            repeat (8) @(negedge clk);
            sck_i = cf;
         end else begin
            sck_i = ~cf;
            mosi_i = mb[bp(lf, i)];
            repeat (8) @(negedge clk);
            got[bp(lf, i)] = miso_o;
            sck_i = cf;
            repeat (8) @(negedge clk);
         end
      end
      repeat (10) @(negedge clk);
      sb_check({tag, " R3 R7 R11 MISO byte"}, got);
      ss_n = 1'b1;
      repeat (4) @(negedge clk);
      chk({tag, " R11 MISO released"}, miso_oe, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(2'd0, v); chk("R1 control reset", v, 8'h00);
      rd(2'd1, v); chk("R1 status reset", v, 8'h00);
      chk("R9 irq reset", irq, 1'b0);
      chk("R11 MISO disabled at reset", miso_oe, 1'b0);

      // control register read back
      wr(2'd0, 8'h93);
      rd(2'd0, v); chk("R1 control readback", v, 8'h93);
      wr(2'd0, 8'h00);

      // disabled module ignores data writes
      wr(2'd0, 8'h10);
      wr(2'd2, 8'hA5);
      repeat (200) @(negedge clk);
      chk("R2 SCK idle while disabled", sck_o, 1'b0);
      rd(2'd1, v); chk("R2 no flag while disabled", v, 8'h00);

      // master transfers across order, polarity, phase and rate
      m_xfer(8'h50, 8'hA3, 8'h5C, 2,  "m0");
      finish_clear("m0");
      m_xfer(8'h75, 8'h1E, 8'hC1, 8,  "m1");
      finish_clear("m1");
      m_xfer(8'h5A, 8'h3A, 8'h4D, 32, "m2");
      finish_clear("m2");
      m_xfer(8'h7F, 8'hE1, 8'h2B, 64, "m3");
      finish_clear("m3");

      // interrupt gating
      m_xfer(8'hD0, 8'h0F, 8'hF2, 2, "m4");
      chk("R9 irq with all enables", irq, 1'b1);
      global_irq_en = 1'b0;
      #1 chk("R9 irq masked by global enable", irq, 1'b0);
      global_irq_en = 1'b1;
      finish_clear("m4");
      chk("R9 irq drops with flag", irq, 1'b0);

      // mode fault
      wr(2'd0, 8'hD0);
      ss_n = 1'b0;
      repeat (6) @(negedge clk);
      rd(2'd0, v); chk("R5 master bit cleared", v, 8'hC0);
      chk("R5 R9 irq on mode fault", irq, 1'b1);
      ss_n = 1'b1;
      rd(2'd1, v); chk("R5 flag on mode fault", v, 8'h80);
      rd(2'd2, v);
      rd(2'd1, v); chk("R5 R10 fault flag cleared", v, 8'h00);
      repeat (4) @(negedge clk);
      rd(2'd0, v); chk("R5 stays slave until rewritten", v, 8'hC0);
      wr(2'd0, 8'h50);
      rd(2'd0, v); chk("R5 master restored by write", v, 8'h50);

      // slave: MSB first, early sample
      s_xfer(8'h40, 8'h6B, 8'hD2, "s0");
      finish_clear("s0");

      // slave unselected: SCK edges ignored
      wr(2'd0, 8'h6F);
      ss_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         sck_i = ~sck_i;
         repeat (4) @(negedge clk);
      end
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
      chk("R11 MISO off while unselected", miso_oe, 1'b0);
      rd(2'd1, v); chk("R11 no flag while unselected", v, 8'h00);

      // slave: LSB first, late sample, idle high, rate bits set
      s_xfer(8'h6F, 8'h17, 8'h9C, "s1");
      finish_clear("s1");

      repeat (10) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule